// File: doc/BRIEF.md
# Serial Port Wake-Up Event Controller

This block raises a wake request for a serial port on a path kept apart from the port's normal interrupt reporting. On the receive side it watches three line-activity indications (receive data, clear-to-send, data-set-ready) and an idle-acknowledge input. When the receive-side wake enable is set, any of them records a sticky wake status bit. On the transmit side it watches the holding-register interrupt, the transmit DMA request and the transmit status event. Each of these counts only when its own enable permits it, and only while the transmit-side wake enable is set.

Every event input is asynchronous to the block clock and passes through a two-stage synchronizer before detection. The sticky status is cleared only by writing the receive-side enable to 0. Software must then write the enable back to 1 to arm the next detection. The wake output is a register holding the OR of the status and the qualified transmit conditions. The interrupt identification logic has no connection to this block.

Top module: `uart_wake_ctrl`

## Requirements
- R1: While `rx_wake_en_i` is 0, `wake_sts_o` is 0 one clock later and stays 0 whatever the receive-side inputs do.
- R2: With `rx_wake_en_i` at 1, a high level on any bit of `line_act_i` (bit 0 receive data, bit 1 clear-to-send, bit 2 data-set-ready) sets `wake_sts_o` and `wake_o` at the third rising clock edge after the input changes.
- R3: `wake_sts_o` is sticky. Only `rx_wake_en_i` = 0 clears it, one clock later. Removing the activity or toggling any transmit-side input leaves it set.
- R4: Activity that occurs and ends while `rx_wake_en_i` is 0 is not recorded. After the enable is written back to 1, only new activity sets the status.
- R5: With `tx_wake_en_i` at 1, a qualified transmit source drives `wake_o` high with three clocks of latency. It is not held, and it never sets `wake_sts_o`. With `tx_wake_en_i` at 0, `wake_o` equals `wake_sts_o`.
- R6: `thr_irq_i` is ignored while `tx_dma_en_i` is 1. `txstat_evt_i` is ignored while `thr_irq_en_i` is 1.
- R7: `txstat_evt_i` counts only when `txstat_en_i` is 1 and `ir_mode_i` is 1 (infrared mode). `tx_dma_req_i` counts only when `tx_dma_en_i` is 1. `thr_irq_i` counts only when `thr_irq_en_i` is 1.
- R8: `idle_ack_i` is a receive-side source. It is sensed as a high level when `ir_mode_i` is 0, and only as a low-to-high transition when `ir_mode_i` is 1.
- R9: If a receive event reaches detection at the same edge where `rx_wake_en_i` is seen at 0, the clear wins and `wake_sts_o` stays 0.
- R10: Synchronous reset drives `wake_sts_o` and `wake_o` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_wake_en_i | input | 1 | Receive-side wake enable (control register bit) |
| tx_wake_en_i | input | 1 | Transmit-side wake enable (control register bit) |
| ir_mode_i | input | 1 | Infrared mode selected |
| thr_irq_en_i | input | 1 | Holding-register interrupt enabled |
| tx_dma_en_i | input | 1 | Transmit DMA requests enabled |
| txstat_en_i | input | 1 | Transmit status event enabled |
| line_act_i | input | LINE_SRCS | Asynchronous line activity: receive data, clear-to-send, data-set-ready |
| idle_ack_i | input | 1 | Asynchronous idle-acknowledge |
| thr_irq_i | input | 1 | Holding-register interrupt condition |
| tx_dma_req_i | input | 1 | Transmit DMA request |
| txstat_evt_i | input | 1 | Transmit status event |
| wake_sts_o | output | 1 | Sticky receive-side wake status |
| wake_o | output | 1 | Registered wake request |

## Verification
Two functions can land on the same edge: the software clear (the receive enable seen at 0) and a newly synchronized receive event. The bench raises a line-activity input and drops the enable exactly two clocks later, so both reach the status register at the same edge. The scoreboard then expects the status and the wake output to stay 0. A second coincidence is a live transmit wake source during an active receive status. Here the expected wake output stays high while the status keeps its own value.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef struct packed {
    logic stat;
    logic dma;
    logic thr;
  } tx_src_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wake_rx_detect.sv
module wake_rx_detect #(
  parameter int LINE_SRCS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ir_mode_i,
  input  logic [LINE_SRCS-1:0] line_s_i,
  input  logic                 idle_s_i,
  output logic                 rx_evt_o
);
  logic idle_prev;
  logic idle_hit;

  always_ff @(posedge clk) begin
    if (rst) idle_prev <= 1'b0;
    else     idle_prev <= idle_s_i;
  end

  // infrared mode: transition only; other modes: level
  always_comb begin
    if (ir_mode_i) idle_hit = idle_s_i & ~idle_prev;
    else           idle_hit = idle_s_i;
  end

  assign rx_evt_o = (|line_s_i) | idle_hit;

  // R8: in infrared mode a held-high idle input yields no event
  p_idle_edge_only_r8: assert property (@(posedge clk) disable iff (rst)
    (ir_mode_i && idle_prev && idle_s_i && !(|line_s_i)) |-> !rx_evt_o);
endmodule

// File: rtl/wake_tx_qual.sv
module wake_tx_qual
  import uart_wake_pkg::*;
(
  input  logic    tx_wake_en_i,
  input  logic    ir_mode_i,
  input  logic    thr_irq_en_i,
  input  logic    tx_dma_en_i,
  input  logic    txstat_en_i,
  input  tx_src_t src_i,
  output logic    tx_wake_o
);
  tx_src_t ok;

  always_comb begin
    ok.thr  = src_i.thr  & thr_irq_en_i & ~tx_dma_en_i;
    ok.dma  = src_i.dma  & tx_dma_en_i;
    ok.stat = src_i.stat & txstat_en_i & ir_mode_i & ~thr_irq_en_i;
    tx_wake_o = tx_wake_en_i & (|ok);
  end
endmodule

// File: rtl/wake_status.sv
module wake_status (
  input  logic clk,
  input  logic rst,
  input  logic rx_en_i,
  input  logic rx_evt_i,
  output logic sts_next_o,
  output logic sts_o
);
  logic sts_q;

  // a dropped enable overrides any arriving event
  assign sts_next_o = rx_en_i & (sts_q | rx_evt_i);

  always_ff @(posedge clk) begin
    if (rst) sts_q <= 1'b0;
    else     sts_q <= sts_next_o;
  end

  assign sts_o = sts_q;

  p_disabled_clears_r1: assert property (@(posedge clk) disable iff (rst)
    !rx_en_i |=> !sts_q);
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_en_i && sts_q) |=> sts_q);
  p_set_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_q) |-> $past(rx_evt_i && rx_en_i));
endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
  import uart_wake_pkg::*;
#(
  parameter int LINE_SRCS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_wake_en_i,
  input  logic                 tx_wake_en_i,
  input  logic                 ir_mode_i,
  input  logic                 thr_irq_en_i,
  input  logic                 tx_dma_en_i,
  input  logic                 txstat_en_i,
  input  logic [LINE_SRCS-1:0] line_act_i,
  input  logic                 idle_ack_i,
  input  logic                 thr_irq_i,
  input  logic                 tx_dma_req_i,
  input  logic                 txstat_evt_i,
  output logic                 wake_sts_o,
  output logic                 wake_o
);
  localparam int SYNC_W = LINE_SRCS + 4;

  logic [SYNC_W-1:0] raw, synced;
  logic [LINE_SRCS-1:0] line_s;
  logic idle_s;
  tx_src_t tx_s;
  logic rx_evt, tx_wake, sts_next, sts;
  logic wake_q;

  assign raw = {txstat_evt_i, tx_dma_req_i, thr_irq_i, idle_ack_i, line_act_i};

  wake_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
  );

  assign line_s  = synced[LINE_SRCS-1:0];
  assign idle_s  = synced[LINE_SRCS];
  assign tx_s.thr  = synced[LINE_SRCS+1];
  assign tx_s.dma  = synced[LINE_SRCS+2];
  assign tx_s.stat = synced[LINE_SRCS+3];

  wake_rx_detect #(.LINE_SRCS(LINE_SRCS)) u_rx (
    .clk(clk), .rst(rst), .ir_mode_i(ir_mode_i),
    .line_s_i(line_s), .idle_s_i(idle_s), .rx_evt_o(rx_evt)
  );

  wake_tx_qual u_tx (
    .tx_wake_en_i(tx_wake_en_i), .ir_mode_i(ir_mode_i),
    .thr_irq_en_i(thr_irq_en_i), .tx_dma_en_i(tx_dma_en_i),
    .txstat_en_i(txstat_en_i), .src_i(tx_s), .tx_wake_o(tx_wake)
  );

  wake_status u_sts (
    .clk(clk), .rst(rst), .rx_en_i(rx_wake_en_i), .rx_evt_i(rx_evt),
    .sts_next_o(sts_next), .sts_o(sts)
  );

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= sts_next | tx_wake;
  end

  assign wake_sts_o = sts;
  assign wake_o     = wake_q;

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!wake_o && !wake_sts_o));
  p_status_drives_wake_r2: assert property (@(posedge clk) disable iff (rst)
    wake_sts_o |-> wake_o);
  p_no_tx_follows_sts_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_wake_en_i |=> (wake_o == wake_sts_o));
endmodule

// File: tb/tb_uart_wake_ctrl.sv
module tb_uart_wake_ctrl;
  logic clk = 1'b0;
  logic rst;
  logic rx_en, tx_en, ir, thr_en, dma_en, stat_en;
  logic [2:0] line;
  logic idle, thr, dma, stat;
  logic wake_sts, wake;

  always #10 clk = ~clk;

  uart_wake_ctrl dut (
    .clk(clk), .rst(rst), .rx_wake_en_i(rx_en), .tx_wake_en_i(tx_en),
    .ir_mode_i(ir), .thr_irq_en_i(thr_en), .tx_dma_en_i(dma_en),
    .txstat_en_i(stat_en), .line_act_i(line), .idle_ack_i(idle),
    .thr_irq_i(thr), .tx_dma_req_i(dma), .txstat_evt_i(stat),
    .wake_sts_o(wake_sts), .wake_o(wake)
  );

  typedef struct {
    string tag;
    logic  w;
    logic  s;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic w, input logic s);
    exp_t e;
    e.tag = tag; e.w = w; e.s = s;
    q.push_back(e);
  endtask

  // monitor: compares just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        tests++;
        if (wake !== e.w || wake_sts !== e.s) begin
          fails++;
          $display("FAIL %s: wake=%b sts=%b expected wake=%b sts=%b",
                   e.tag, wake, wake_sts, e.w, e.s);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_en = 0; tx_en = 0; ir = 0; thr_en = 0; dma_en = 0; stat_en = 0;
    line = '0; idle = 0; thr = 0; dma = 0; stat = 0;
    tick(3);
    expect_out("R10 reset state", 1'b0, 1'b0);
    rst = 1'b0;
    tick(2);

    // R1: activity while disabled
    line = 3'b001;
    tick(5);
    expect_out("R1 disabled ignores rx", 1'b0, 1'b0);

    // R2: latency from clear-to-send activity
    line = 3'b000; tick(4);
    rx_en = 1; tick(2);
    line = 3'b010;
    tick(2);
    expect_out("R2 not yet set after two edges", 1'b0, 1'b0);
    tick(1);
    expect_out("R2 set on third edge", 1'b1, 1'b1);

    // R3: sticky despite activity removal and tx input toggles
    line = 3'b000; thr = 1; dma = 1; stat = 1; ir = 1;
    tick(5);
    expect_out("R3 sticky after activity gone", 1'b1, 1'b1);
    thr = 0; dma = 0; stat = 0; ir = 0;
    tick(5);
    expect_out("R3 sticky after tx toggles", 1'b1, 1'b1);
    rx_en = 0;
    tick(1);
    expect_out("R3 cleared one edge after enable drop", 1'b0, 1'b0);

    // R4: activity during disable not recorded
    line = 3'b100; tick(5); line = 3'b000; tick(5);
    rx_en = 1; tick(5);
    expect_out("R4 old activity not recorded", 1'b0, 1'b0);
    line = 3'b100; tick(4);
    expect_out("R4 new activity recorded", 1'b1, 1'b1);
    line = 3'b000; rx_en = 0; tick(3);

    // R5: transmit holding-register source
    tx_en = 1; thr_en = 1; thr = 1;
    tick(2);
    expect_out("R5 tx wake not before third edge", 1'b0, 1'b0);
    tick(1);
    expect_out("R5 tx wake without status", 1'b1, 1'b0);
    thr = 0; tick(4);
    expect_out("R5 tx wake not held", 1'b0, 1'b0);

    // R6: holding-register ignored under DMA
    thr = 1; dma_en = 1; tick(4);
    expect_out("R6 thr masked by dma enable", 1'b0, 1'b0);
    dma = 1; tick(4);
    expect_out("R7 dma request wakes", 1'b1, 1'b0);
    dma = 0; thr = 0; dma_en = 0; tick(4);
    dma = 1; tick(4);
    expect_out("R7 dma request ignored when dma disabled", 1'b0, 1'b0);
    dma = 0;

    // R7 / R6: transmit status event
    thr_en = 0; stat_en = 1; stat = 1; ir = 1; tick(4);
    expect_out("R7 status event in infrared mode", 1'b1, 1'b0);
    ir = 0; tick(2);
    expect_out("R7 status event ignored outside infrared", 1'b0, 1'b0);
    ir = 1; thr_en = 1; tick(2);
    expect_out("R6 status event blocked by thr enable", 1'b0, 1'b0);
    thr_en = 0; tx_en = 0; tick(2);
    expect_out("R5 tx enable off gives no wake", 1'b0, 1'b0);
    stat = 0; stat_en = 0; tick(3);

    // R8: idle acknowledge, level vs transition
    ir = 0; rx_en = 1; idle = 1; tick(4);
    expect_out("R8 idle level wakes outside infrared", 1'b1, 1'b1);
    rx_en = 0; ir = 1; tick(3);
    rx_en = 1; tick(4);
    expect_out("R8 held idle ignored in infrared", 1'b0, 1'b0);
    idle = 0; tick(4);
    idle = 1; tick(4);
    expect_out("R8 idle rising edge wakes in infrared", 1'b1, 1'b1);
    idle = 0; ir = 0; rx_en = 0; tick(4);

    // R9: clear and event on the same edge
    rx_en = 1; tick(2);
    line = 3'b001;
    tick(2);
    rx_en = 0;
    tick(1);
    expect_out("R9 clear wins over event", 1'b0, 1'b0);
    tick(3);
    expect_out("R9 stays clear while disabled", 1'b0, 1'b0);

    // coincidence of tx wake with receive status
    rx_en = 1; tick(2);
    tx_en = 1; thr_en = 1; thr = 1; tick(4);
    expect_out("R5 tx and rx together", 1'b1, 1'b1);
    rx_en = 0; tick(1);
    expect_out("R5 tx keeps wake after status clear", 1'b1, 1'b0);
    thr = 0; line = 3'b000; tick(4);
    expect_out("R5 all quiet", 1'b0, 1'b0);

    // R10: reset while status set
    tx_en = 0; thr_en = 0; rx_en = 1; line = 3'b010; tick(4);
    rst = 1; tick(1);
    expect_out("R10 reset clears set status", 1'b0, 1'b0);
    rst = 0; line = 3'b000; rx_en = 0;

    tick(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule